// File: doc/BRIEF.md
# Shared-Bus Ownership Handshake Controller

This block decides when a processor may drive an operand address/data bus that other masters also use. When the core asks for the bus, the block pulls its active-low request line. It then waits for an external arbiter to give it priority on the grant line. Even with priority, it does not take the bus until the busy line shows that the current owner has let go.

Once it owns the bus, the block drives an active-low acknowledge and enables its read/write, address and data drivers. It runs a repeating four-phase bus cycle counter. When the core reports that it has finished, the block completes the current cycle. It lifts the data strobe one clock after the last phase, and one clock after that it floats the acknowledge, read/write, address and data pins.

Grant and busy come from other clock domains, so each passes through a two-flop synchronizer before the state machine uses it. Each floating pin has its own output enable.

Top module: `bus_own_ctrl`

## Requirements
- R1: After reset, req_n_o, ack_n_o and strobe_n_o are 1, bus_owned_o is 0, all four output enables are 0 and phase_o is 0.
- R2: With the block idle, core_req_i high at a clock edge drives req_n_o to 0 after that edge, and req_n_o stays 0 until ownership is taken.
- R3: grant_n_i and busy_n_i are only used through two synchronizing flops. With the block requesting and busy_n_i already 1, driving grant_n_i to 0 makes ack_n_o go to 0 after the fourth clock edge, and not earlier.
- R4: While grant is held (grant_n_i=0) and busy_n_i is 0, no ownership is taken. After busy_n_i goes to 1, ack_n_o goes to 0 after the third clock edge.
- R5: If grant_n_i returns to 1 before ownership is taken, the block goes back to requesting: req_n_o stays 0, and a later release of busy does not give ownership without a new grant.
- R6: In the cycle ownership begins, ack_n_o becomes 0 with ack_oe_o=1, and req_n_o becomes 1 in that same cycle. rw_oe_o, addr_oe_o and data_oe_o are 1, strobe_n_o is 0 and bus_owned_o is 1.
- R7: phase_o is 0 (phase one) in the first owned cycle and advances by one each clock while owned, wrapping from 3 to 0. It is 0 whenever the bus is not owned.
- R8: Ownership ends at a clock edge where phase_o=3 and a done request is pending. In the next cycle strobe_n_o is 1 and bus_owned_o is 0, while ack_n_o stays 0 and every enable stays 1. One clock later all four enables are 0, ack_n_o is 1 and the block is idle.
- R9: While the bus is owned, grant_n_i returning to 1 or busy_n_i going to 0 has no effect on ownership.
- R10: A core_done_i pulse of one clock in any owned phase is remembered until the end of phase 3 of that bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req_i | input | 1 | Core needs the operand buses |
| core_done_i | input | 1 | Core no longer needs the buses (pulse) |
| bus_owned_o | output | 1 | Block currently owns the bus |
| req_n_o | output | 1 | Bus request, active low |
| grant_n_i | input | 1 | Arbiter priority grant, active low |
| busy_n_i | input | 1 | Another master holds the bus, active low |
| ack_n_o | output | 1 | Grant acknowledge, active low |
| ack_oe_o | output | 1 | Drive enable for ack_n_o |
| rw_oe_o | output | 1 | Drive enable for the read/write line |
| addr_oe_o | output | 1 | Drive enable for the address bus |
| data_oe_o | output | 1 | Drive enable for the data bus |
| strobe_n_o | output | 1 | Data strobe, active low |
| phase_o | output | 2 | Current bus cycle phase, 0 to 3 |

## Verification
The assertions check on every cycle that ownership follows only a synchronized grant with a released busy line, that request and acknowledge change in the same cycle, that the phase steps and wraps, that ownership holds until a pending done meets phase 3, and that the strobe lifts one cycle before the enables drop. Only the bench scenarios can show the exact edge counts through the synchronizers, the return to requesting when the grant is withdrawn, and that a done pulse given early is kept until the end of the bus cycle.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQUEST = 3'd1,
    ST_WAIT    = 3'd2,
    ST_OWN     = 3'd3,
    ST_RELEASE = 3'd4
  } own_state_t;

  // next phase of a cycle counter with modulo wrap
  function automatic logic [7:0] phase_next(input logic [7:0] cur, input int unsigned n);
    return (cur == 8'(n - 1)) ? 8'd0 : cur + 8'd1;
  endfunction
endpackage

// File: rtl/bus_own_sync.sv
module bus_own_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bus_own_phase.sv
module bus_own_phase
  import bus_own_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 4,
  localparam int unsigned PH_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  logic [7:0] nxt_wide;

  assign nxt_wide = phase_next(8'(phase_o), NUM_PHASES);
  assign last_o   = (phase_o == PH_W'(NUM_PHASES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_o <= '0;
    else if (!run_i) phase_o <= '0;
    else             phase_o <= nxt_wide[PH_W-1:0];
  end

  // R7
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && last_o) |=> (phase_o == '0));

  // R7
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !last_o) |=> (phase_o == PH_W'($past(phase_o) + 1'b1)) || (phase_o == '0));
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_PHASES = 4,
  localparam int unsigned PH_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_req_i,
  input  logic            core_done_i,
  output logic            bus_owned_o,
  output logic            req_n_o,
  input  logic            grant_n_i,
  input  logic            busy_n_i,
  output logic            ack_n_o,
  output logic            ack_oe_o,
  output logic            rw_oe_o,
  output logic            addr_oe_o,
  output logic            data_oe_o,
  output logic            strobe_n_o,
  output logic [PH_W-1:0] phase_o
);
  own_state_t state_q, state_d;
  logic [1:0] pins_sync;
  logic       grant_s, busy_s;
  logic       done_pend_q;
  logic       phase_last;
  logic       take_bus, leave_own, drop_grant;

  bus_own_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({busy_n_i, grant_n_i}),
    .q_o   (pins_sync)
  );
  assign grant_s = ~pins_sync[0];
  assign busy_s  = ~pins_sync[1];

  bus_own_phase #(.NUM_PHASES(NUM_PHASES)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (state_q == ST_OWN),
    .phase_o (phase_o),
    .last_o  (phase_last)
  );

  // named events for the checks
  assign take_bus   = (state_q == ST_WAIT) && grant_s && !busy_s;
  assign drop_grant = (state_q == ST_WAIT) && !grant_s;
  assign leave_own  = (state_q == ST_OWN) && phase_last && (done_pend_q || core_done_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (core_req_i) state_d = ST_REQUEST;
      ST_REQUEST: if (grant_s) state_d = ST_WAIT;
      ST_WAIT: begin
        if (drop_grant)    state_d = ST_REQUEST;
        else if (take_bus) state_d = ST_OWN;
      end
      ST_OWN:     if (leave_own) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      done_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_OWN || leave_own) done_pend_q <= 1'b0;
      else if (core_done_i)               done_pend_q <= 1'b1;
    end
  end

  // all pin values decode from the state register
  logic driving;
  assign driving     = (state_q == ST_OWN) || (state_q == ST_RELEASE);
  assign bus_owned_o = (state_q == ST_OWN);
  assign req_n_o     = !((state_q == ST_REQUEST) || (state_q == ST_WAIT));
  assign ack_n_o     = !driving;
  assign ack_oe_o    = driving;
  assign rw_oe_o     = driving;
  assign addr_oe_o   = driving;
  assign data_oe_o   = driving;
  assign strobe_n_o  = !(state_q == ST_OWN);

  // R6
  take_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_bus |=> (!ack_n_o && ack_oe_o && req_n_o && !strobe_n_o && phase_o == '0));

  // R3
  ack_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe_o) |-> ($past(grant_s) && !$past(busy_s)));

  // R9
  hold_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owned_o && !leave_own) |=> bus_owned_o);

  // R8
  strobe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave_own |=> (strobe_n_o && !ack_n_o && ack_oe_o && addr_oe_o && data_oe_o && rw_oe_o));

  // R8
  float_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe_o && !bus_owned_o) |=> (!ack_oe_o && ack_n_o && !addr_oe_o && !data_oe_o && !rw_oe_o));

  // R5
  regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_grant |=> (!req_n_o && !ack_oe_o));
endmodule

// File: tb/bus_own_ctrl_bench.sv
module bus_own_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_req = 1'b0, core_done = 1'b0;
  logic grant_n = 1'b1, busy_n = 1'b1;
  logic owned, req_n, ack_n, ack_oe, rw_oe, addr_oe, data_oe, strobe_n;
  logic [1:0] phase;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_own_ctrl u_bus_own_ctrl (
    .clk(clk), .rst_n(rst_n), .core_req_i(core_req), .core_done_i(core_done),
    .bus_owned_o(owned), .req_n_o(req_n), .grant_n_i(grant_n), .busy_n_i(busy_n),
    .ack_n_o(ack_n), .ack_oe_o(ack_oe), .rw_oe_o(rw_oe), .addr_oe_o(addr_oe),
    .data_oe_o(data_oe), .strobe_n_o(strobe_n), .phase_o(phase)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  // packs {owned, req_n, ack_n, ack_oe, rw_oe, addr_oe, data_oe, strobe_n}
  function automatic int pins();
    return {owned, req_n, ack_n, ack_oe, rw_oe, addr_oe, data_oe, strobe_n};
  endfunction
  localparam int P_IDLE  = 8'b0_1_1_0_0_0_0_1;
  localparam int P_REQ   = 8'b0_0_1_0_0_0_0_1;
  localparam int P_OWN   = 8'b1_1_0_1_1_1_1_0;
  localparam int P_RELSE = 8'b0_1_0_1_1_1_1_1;

  task automatic t_reset();
    chk("R1 pins after reset", pins(), P_IDLE);
    chk("R1 phase after reset", phase, 0);
  endtask

  task automatic t_basic();
    core_req = 1'b1;
    tick(1);
    chk("R2 request low", pins(), P_REQ);
    grant_n = 1'b0;
    tick(3);
    chk("R3 no ack after 3 edges", pins(), P_REQ);
    tick(1);
    chk("R3 R6 owned after 4 edges", pins(), P_OWN);
    chk("R7 phase zero on entry", phase, 0);
    core_req = 1'b0;
    core_done = 1'b1;
    tick(1);
    core_done = 1'b0;
    chk("R10 still owned ph1", pins(), P_OWN);
    chk("R7 phase 1", phase, 1);
    tick(1);
    chk("R7 phase 2", phase, 2);
    tick(1);
    chk("R10 owned in ph3", pins(), P_OWN);
    chk("R7 phase 3", phase, 3);
    tick(1);
    chk("R8 strobe up, still driving", pins(), P_RELSE);
    chk("R7 phase zero when not owned", phase, 0);
    tick(1);
    chk("R8 floated and idle", pins(), P_IDLE);
    grant_n = 1'b1;
    tick(3);
  endtask

  task automatic t_busy_wait();
    core_req = 1'b1;
    busy_n = 1'b0;
    tick(1);
    grant_n = 1'b0;
    tick(8);
    chk("R4 held off by busy", pins(), P_REQ);
    busy_n = 1'b1;
    tick(2);
    chk("R4 no ack after 2 edges", pins(), P_REQ);
    tick(1);
    chk("R4 owned after 3 edges", pins(), P_OWN);
    core_req = 1'b0;
    tick(4);
    chk("R7 wrap to 0 still owned", phase, 0);
    chk("R7 owned after wrap", pins(), P_OWN);
    tick(3);
    chk("R7 phase 3 second cycle", phase, 3);
    core_done = 1'b1;
    tick(1);
    core_done = 1'b0;
    chk("R8 done in ph3 releases", pins(), P_RELSE);
    tick(1);
    chk("R8 idle after release", pins(), P_IDLE);
    grant_n = 1'b1;
    tick(3);
  endtask

  task automatic t_grant_withdraw();
    core_req = 1'b1;
    busy_n = 1'b0;
    tick(1);
    grant_n = 1'b0;
    tick(4);
    grant_n = 1'b1;
    tick(4);
    chk("R5 still requesting", pins(), P_REQ);
    busy_n = 1'b1;
    tick(6);
    chk("R5 no ownership without grant", pins(), P_REQ);
    grant_n = 1'b0;
    tick(3);
    chk("R5 no ack before 4 edges", pins(), P_REQ);
    tick(1);
    chk("R5 owned after regrant", pins(), P_OWN);
    core_req = 1'b0;
    // R9: arbiter lines change during ownership
    grant_n = 1'b1;
    busy_n = 1'b0;
    tick(6);
    chk("R9 ownership kept", pins(), P_OWN);
    chk("R9 phase keeps counting", phase, 2);
    core_done = 1'b1;
    tick(1);
    core_done = 1'b0;
    chk("R10 ph3 after done", phase, 3);
    chk("R10 owned ph3", pins(), P_OWN);
    tick(1);
    chk("R8 release", pins(), P_RELSE);
    tick(1);
    chk("R8 idle", pins(), P_IDLE);
    busy_n = 1'b1;
    tick(3);
  endtask

  bit done_flag = 1'b0;
  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_basic();
    t_busy_wait();
    t_grant_withdraw();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule